// File: doc/BRIEF.md
# Circuit-Switched Port Router

This block joins a small group of nodes on one chip. Each node can act as a master, asking for a private path to one other node, and as a target, receiving words from whichever master holds a path to it. A master names its target by an address. A routing table turns that address into a port number. If the target is free, the router answers with a one-cycle grant. From then on the crossbar connects the master's write lane directly to the target's read lane, with no per-word acknowledgement. The only flow control is the target's clear-to-send, which is returned to the master in the same cycle.

Requests for a busy target wait in a per-source pending slot. When the target is released, a round-robin arbiter picks one waiting source. A master tears its circuit down with a one-cycle release pulse. Addresses outside the table, and addresses that point back to the requesting port, are refused with a one-cycle refusal pulse.

Top module: `csw_router`

## Requirements
- R1: After reset no grant or refusal is pulsed, no circuit exists, every `rx_valid_o` bit is 0 and every `tx_cts_o` bit is 0.
- R2: Port p answers address BASE+p. A request pulse for a free, valid target that is not the requester's own port is sampled at clock edge E. The requester's `grant_o` bit is then 1 only between edges E+1 and E+2, and the circuit is in place from edge E+1.
- R3: A request whose address lies outside BASE..BASE+N-1, or maps to the requester's own port, raises the requester's `refuse_o` bit for exactly the cycle after edge E and is never granted.
- R4: While a circuit from source s to target t exists, `rx_data_o[t]` equals `tx_data_i[s]` and `rx_valid_o[t]` equals `tx_valid_i[s]` in the same cycle. Words pass on consecutive cycles with no acknowledgement.
- R5: While source s holds a circuit to target t, `tx_cts_o[s]` equals `rx_cts_i[t]` in the same cycle. A port that holds no circuit sees `tx_cts_o` at 0.
- R6: Circuits between disjoint port pairs carry data at the same time, without affecting each other.
- R7: A request for a busy target is held and is not granted while the target is busy. If the owner's release is sampled at edge E, the waiting source is granted with its grant bit high between edges E+1 and E+2.
- R8: Waiting requests for one target are served round-robin. The search starts at the port after the last one granted that target (port 0 after reset) and wraps at N-1.
- R9: At most one grant is issued per target per cycle. A circuit keeps its owner until that owner releases it.
- R10: A request from a port that already holds a circuit or a pending request is ignored. The existing circuit still carries data, no grant or refusal is pulsed, and the ignored target stays free for others.
- R11: A release pulse sampled at edge E removes the requester's circuit from edge E. From then the target's `rx_valid_o` bit is 0 and the source's `tx_cts_o` bit is 0. A release from a port without a circuit has no effect.
- R12: A valid word from a port that holds no circuit reaches no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Per-port connection request pulse |
| tgt_addr_i | input | N x AW | Per-port target address, sampled with the request |
| rel_i | input | N | Per-port release pulse |
| grant_o | output | N | Per-port one-cycle grant |
| refuse_o | output | N | Per-port one-cycle refusal |
| tx_data_i | input | N x DW | Master-side write data per port |
| tx_valid_i | input | N | Master-side word valid per port |
| tx_cts_o | output | N | Clear-to-send returned to each master |
| rx_data_o | output | N x DW | Target-side data per port |
| rx_valid_o | output | N | Target-side word valid per port |
| rx_cts_i | input | N | Target-side clear-to-send per port |

## Verification
The bench builds the router with four ports, 16-bit data, 4-bit addresses and a base address of 4. Valid targets are therefore addresses 4 to 7, and the values 2, 8 and a requester's own address all lie within reach of the refusal path. Four ports are enough to hold two disjoint circuits at once while a third source waits. They also let three sources contend for one target, which makes the rotation of the round-robin pointer visible through the order of the grants.

// File: rtl/csw_pkg.sv
package csw_pkg;

    // What the router does with a newly sampled request pulse
    typedef enum logic [1:0] {
        REQ_NONE   = 2'd0,
        REQ_QUEUE  = 2'd1,
        REQ_REFUSE = 2'd2
    } req_act_e;

    function automatic req_act_e classify(input logic pulse, input logic busy_src,
                                          input logic hit, input logic self_hit);
        if (!pulse || busy_src)  return REQ_NONE;
        if (!hit || self_hit)    return REQ_REFUSE;
        return REQ_QUEUE;
    endfunction

endpackage

// File: rtl/csw_route_table.sv
module csw_route_table #(
    parameter int N    = 4,
    parameter int AW   = 4,
    parameter int BASE = 4,
    parameter int PW   = 2
) (
    input  logic [AW-1:0] addr_i,
    output logic          hit_o,
    output logic [PW-1:0] port_o
);
    // entry i: address BASE+i routes to crossbar port i
    always_comb begin
        hit_o  = 1'b0;
        port_o = '0;
        for (int i = 0; i < N; i++) begin
            if (addr_i == AW'(BASE + i)) begin
                hit_o  = 1'b1;
                port_o = PW'(i);
            end
        end
    end
endmodule

// File: rtl/csw_rr_arb.sv
module csw_rr_arb #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  req_i,
    input  logic [PW-1:0] ptr_i,
    output logic          vld_o,
    output logic [PW-1:0] idx_o
);
    // search upward from ptr_i with wrap; nearest requester wins
    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = (int'(ptr_i) + k) % N;
            if (req_i[j]) begin
                vld_o = 1'b1;
                idx_o = PW'(j);
            end
        end
    end
endmodule

// File: rtl/csw_xbar.sv
module csw_xbar #(
    parameter int N  = 4,
    parameter int DW = 16,
    parameter int PW = 2
) (
    input  logic [N-1:0]          busy_i,
    input  logic [N-1:0][PW-1:0]  owner_i,
    input  logic [N-1:0]          conn_i,
    input  logic [N-1:0][PW-1:0]  conn_tgt_i,
    input  logic [N-1:0][DW-1:0]  tx_data_i,
    input  logic [N-1:0]          tx_valid_i,
    input  logic [N-1:0]          rx_cts_i,
    output logic [N-1:0][DW-1:0]  rx_data_o,
    output logic [N-1:0]          rx_valid_o,
    output logic [N-1:0]          tx_cts_o
);
    for (genvar p = 0; p < N; p++) begin : g_lane
        // forward lane: target p listens to its owner
        assign rx_data_o[p]  = busy_i[p] ? tx_data_i[owner_i[p]] : '0;
        assign rx_valid_o[p] = busy_i[p] & tx_valid_i[owner_i[p]];
        // return lane: master p sees its target's clear-to-send
        assign tx_cts_o[p]   = conn_i[p] & rx_cts_i[conn_tgt_i[p]];
    end
endmodule

// File: rtl/csw_router.sv
module csw_router
    import csw_pkg::*;
#(
    parameter int N    = 4,
    parameter int DW   = 16,
    parameter int AW   = 4,
    parameter int BASE = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req_i,
    input  logic [N-1:0][AW-1:0] tgt_addr_i,
    input  logic [N-1:0]         rel_i,
    output logic [N-1:0]         grant_o,
    output logic [N-1:0]         refuse_o,
    input  logic [N-1:0][DW-1:0] tx_data_i,
    input  logic [N-1:0]         tx_valid_i,
    output logic [N-1:0]         tx_cts_o,
    output logic [N-1:0][DW-1:0] rx_data_o,
    output logic [N-1:0]         rx_valid_o,
    input  logic [N-1:0]         rx_cts_i
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]         pend;      // per-source waiting slot
        logic [N-1:0][PW-1:0] pend_tgt;
        logic [N-1:0]         conn;      // source holds a circuit
        logic [N-1:0][PW-1:0] conn_tgt;
        logic [N-1:0]         busy;      // target is owned
        logic [N-1:0][PW-1:0] owner;
        logic [N-1:0][PW-1:0] rr;        // per-target search start
        logic [N-1:0]         grant;
        logic [N-1:0]         refuse;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]          hit;
    logic [N-1:0][PW-1:0]  hit_port;
    logic [N-1:0][N-1:0]   cand;     // cand[t][s]: s waits for t
    logic [N-1:0]          win_vld;
    logic [N-1:0][PW-1:0]  win_idx;

    for (genvar p = 0; p < N; p++) begin : g_route
        csw_route_table #(.N(N), .AW(AW), .BASE(BASE), .PW(PW)) u_rt (
            .addr_i (tgt_addr_i[p]),
            .hit_o  (hit[p]),
            .port_o (hit_port[p])
        );
    end

    always_comb begin
        for (int t = 0; t < N; t++) begin
            for (int s = 0; s < N; s++) begin
                cand[t][s] = st_q.pend[s] && (st_q.pend_tgt[s] == PW'(t)) && !st_q.busy[t];
            end
        end
    end

    for (genvar t = 0; t < N; t++) begin : g_arb
        csw_rr_arb #(.N(N), .PW(PW)) u_arb (
            .req_i (cand[t]),
            .ptr_i (st_q.rr[t]),
            .vld_o (win_vld[t]),
            .idx_o (win_idx[t])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.grant  = '0;
        st_d.refuse = '0;

        // new requests
        for (int s = 0; s < N; s++) begin
            req_act_e act;
            act = classify(req_i[s], st_q.pend[s] | st_q.conn[s], hit[s],
                           hit_port[s] == PW'(s));
            case (act)
                REQ_QUEUE: begin
                    st_d.pend[s]     = 1'b1;
                    st_d.pend_tgt[s] = hit_port[s];
                end
                REQ_REFUSE: st_d.refuse[s] = 1'b1;
                default: ;
            endcase
        end

        // teardown
        for (int s = 0; s < N; s++) begin
            if (rel_i[s] && st_q.conn[s]) begin
                st_d.conn[s]                = 1'b0;
                st_d.busy[st_q.conn_tgt[s]] = 1'b0;
            end
        end

        // one winner per free target
        for (int t = 0; t < N; t++) begin
            if (win_vld[t]) begin
                st_d.pend[win_idx[t]]     = 1'b0;
                st_d.conn[win_idx[t]]     = 1'b1;
                st_d.conn_tgt[win_idx[t]] = PW'(t);
                st_d.grant[win_idx[t]]    = 1'b1;
                st_d.busy[t]              = 1'b1;
                st_d.owner[t]             = win_idx[t];
                st_d.rr[t]                = (int'(win_idx[t]) == N - 1) ? '0
                                            : PW'(int'(win_idx[t]) + 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o  = st_q.grant;
    assign refuse_o = st_q.refuse;

    csw_xbar #(.N(N), .DW(DW), .PW(PW)) u_xbar (
        .busy_i     (st_q.busy),
        .owner_i    (st_q.owner),
        .conn_i     (st_q.conn),
        .conn_tgt_i (st_q.conn_tgt),
        .tx_data_i  (tx_data_i),
        .tx_valid_i (tx_valid_i),
        .rx_cts_i   (rx_cts_i),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o),
        .tx_cts_o   (tx_cts_o)
    );

    // ---------------- checks ----------------
    logic [N-1:0][N-1:0] claim;   // claim[t][s]: s's circuit points at t
    always_comb begin
        for (int t = 0; t < N; t++)
            for (int s = 0; s < N; s++)
                claim[t][s] = st_q.conn[s] && (st_q.conn_tgt[s] == PW'(t));
    end

    for (genvar p = 0; p < N; p++) begin : g_chk
        // R9
        single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(claim[p]) <= 1) && (st_q.busy[p] == (claim[p] != '0)));
        // R9
        owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.busy[p] && !rel_i[st_q.owner[p]]) |=> (st_q.busy[p] && $stable(st_q.owner[p])));
        // R7
        grant_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.grant[p]) |-> $past(st_q.pend[p]));
        // R3
        refuse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(st_q.grant[p] && st_q.refuse[p]));
        // R5
        cts_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !st_q.conn[p] |-> !tx_cts_o[p]);
        // R10
        no_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(st_q.pend[p] && st_q.conn[p]));
    end

endmodule

// File: tb/sim_csw_router.sv
module sim_csw_router;
    localparam int N = 4, DW = 16, AW = 4, BASE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]         req = '0;
    logic [N-1:0][AW-1:0] addr = '0;
    logic [N-1:0]         rel = '0;
    logic [N-1:0]         grant, refuse, tx_cts, rx_valid;
    logic [N-1:0][DW-1:0] tx_data = '0;
    logic [N-1:0]         tx_valid = '0;
    logic [N-1:0][DW-1:0] rx_data;
    logic [N-1:0]         rx_cts = '1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10ns clk = ~clk;

    csw_router #(.N(N), .DW(DW), .AW(AW), .BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .tgt_addr_i(addr), .rel_i(rel),
        .grant_o(grant), .refuse_o(refuse), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
        .tx_cts_o(tx_cts), .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_cts_i(rx_cts)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_req(input int s, input logic [AW-1:0] a);
        req[s] = 1'b1; addr[s] = a;
        tick();
        req[s] = 1'b0;
    endtask

    task automatic pulse_rel(input int s);
        rel[s] = 1'b1;
        tick();
        rel[s] = 1'b0;
    endtask

    // request, then expect the grant one edge later (R2 timing)
    task automatic open_ckt(input int s, input logic [AW-1:0] a, input string tag);
        pulse_req(s, a);
        chk(grant == '0, {tag, " grant not early"}, grant, 0);
        tick();
        chk(grant == 4'(1 << s), {tag, " grant"}, grant, 1 << s);
    endtask

    task automatic t_reset();
        chk(grant == '0 && refuse == '0, "R1 pulses idle", {grant, refuse}, 0);
        chk(rx_valid == '0, "R1 rx_valid", rx_valid, 0);
        chk(tx_cts == '0, "R1 tx_cts", tx_cts, 0);
    endtask

    task automatic t_basic();
        open_ckt(0, 4'd5, "R2");
        tick();
        chk(grant == '0, "R2 grant is one pulse", grant, 0);
        for (int i = 0; i < 3; i++) begin
            tx_data[0] = 16'hA500 + 16'(i); tx_valid[0] = 1'b1;
            #1ns;
            chk(rx_data[1] == 16'hA500 + 16'(i) && rx_valid == 4'b0010, "R4 word passes",
                {rx_data[1], 12'h0, rx_valid}, {16'hA500 + 16'(i), 16'h0002});
            tick();
        end
        rx_cts[1] = 1'b0; #1ns;
        chk(tx_cts == 4'b0000, "R5 cts low forwarded", tx_cts, 0);
        rx_cts[1] = 1'b1; #1ns;
        chk(tx_cts == 4'b0001, "R5 cts high forwarded", tx_cts, 1);
        tx_valid[2] = 1'b1; tx_data[2] = 16'hDEAD; #1ns;
        chk(rx_valid == 4'b0010, "R12 idle source reaches nothing", rx_valid, 2);
        tx_valid[2] = 1'b0;
    endtask

    task automatic t_ignore_and_parallel();
        pulse_req(0, 4'd6);
        chk(refuse == '0, "R10 no refusal", refuse, 0);
        tick();
        chk(grant == '0, "R10 no grant", grant, 0);
        tx_data[0] = 16'h1234; #1ns;
        chk(rx_valid == 4'b0010 && rx_data[1] == 16'h1234, "R10 old circuit kept", rx_data[1], 16'h1234);
        open_ckt(3, 4'd6, "R10 target stays free");
        tx_valid[3] = 1'b1; tx_data[3] = 16'h5678; #1ns;
        chk(rx_valid == 4'b0110 && rx_data[1] == 16'h1234 && rx_data[2] == 16'h5678,
            "R6 two circuits", {rx_data[2], rx_data[1]}, {16'h5678, 16'h1234});
        pulse_rel(0);
        chk(rx_valid == 4'b0100 && tx_cts == 4'b1000, "R11 circuit removed", {tx_cts, rx_valid}, 8'h84);
        pulse_rel(2);
        chk(rx_valid == 4'b0100 && rx_data[2] == 16'h5678, "R11 stray release ignored", rx_valid, 4);
        pulse_rel(3);
        tx_valid = '0;
        chk(rx_valid == '0 && tx_cts == '0, "R11 all torn down", {tx_cts, rx_valid}, 0);
    endtask

    task automatic t_refuse();
        logic [AW-1:0] bad [3] = '{4'd2, 4'd8, 4'd5};
        for (int i = 0; i < 3; i++) begin
            pulse_req(1, bad[i]);
            chk(refuse == 4'b0010, "R3 refusal pulse", refuse, 2);
            tick();
            chk(refuse == '0 && grant == '0, "R3 never granted", {refuse, grant}, 0);
        end
    endtask

    task automatic t_queue_rr();
        open_ckt(0, 4'd7, "R2 port3");
        pulse_req(1, 4'd7);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(grant == '0, "R7 held while busy", grant, 0);
        end
        pulse_rel(0);
        chk(grant == '0, "R7 not early", grant, 0);
        tick();
        chk(grant == 4'b0010, "R7 granted after release", grant, 2);
        req[0] = 1'b1; addr[0] = 4'd7; req[2] = 1'b1; addr[2] = 4'd7;
        tick();
        req = '0;
        tick(); tick();
        chk(grant == '0, "R7 both wait", grant, 0);
        pulse_rel(1);
        tick();
        chk(grant == 4'b0100, "R8 rotation skips port0", grant, 4);
        pulse_rel(2);
        tick();
        chk(grant == 4'b0001, "R8 port0 served next", grant, 1);
        pulse_rel(0);
    endtask

    task automatic t_same_cycle();
        req[1] = 1'b1; addr[1] = 4'd4; req[2] = 1'b1; addr[2] = 4'd4;
        tick();
        req = '0;
        tick();
        chk(grant == 4'b0010, "R9 one grant per target", grant, 2);
        pulse_rel(1);
        tick();
        chk(grant == 4'b0100, "R9 loser served later", grant, 4);
        pulse_rel(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_ignore_and_parallel();
        t_refuse();
        t_queue_rr();
        t_same_cycle();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #4ms;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule